// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

The block holds a 64-bit signed accumulator as two 32-bit halves, a high half and a low half. On each start strobe it multiplies two signed operands and adds the product to the accumulator. The long form takes the full 32-bit operands. The word form takes only the low 16 bits of each operand, each sign-extended.

A saturation-mode input changes what is written back, and the two forms clamp in different ways. In the long form, only bits of the high half are forced or cleared, depending on the sign of the sum. In the word form, a sum outside the signed 32-bit range is replaced by a clamped low half, and the high half is set to 1 as an overflow marker.

A synchronous clear and a direct write port for either half let control logic set the accumulator to a known value before a run. The result is registered, and a done pulse follows each accepted operation by one cycle.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, acc_hi_o, acc_lo_o and done_o are all 0.
- R2: Long form (op_word_i=0) with sat_mode_i=0: {acc_hi_o,acc_lo_o} becomes the old 64-bit value plus the signed product of the full 32-bit opa_i and opb_i, taken modulo 2^64.
- R3: Word form (op_word_i=1) with sat_mode_i=0: the multiplicands are opa_i[15:0] and opb_i[15:0], each sign-extended, and the full 64-bit sum is written back. Bits [31:16] of both operands have no effect.
- R4: Long form with sat_mode_i=1: the low half takes sum[31:0]. If sum bit 63 is 1, the high half is sum[63:32] with bits [31:16] forced to 1. Otherwise the high half is sum[63:32] with bits [31:15] cleared.
- R5: Word form with sat_mode_i=1 and a sum greater than 2^31-1: the high half becomes 1 and the low half becomes 0x7FFFFFFF.
- R6: Word form with sat_mode_i=1 and a sum less than -2^31: the high half becomes 1 and the low half becomes 0x80000000.
- R7: Word form with sat_mode_i=1 and a sum within [-2^31, 2^31-1]: the full 64-bit sum is written back unchanged.
- R8: clear_i zeroes both halves on the next edge. It takes priority over writes and over start_i.
- R9: wr_hi_en_i or wr_lo_en_i loads wr_data_i into the selected half, and both may be set together. When clear_i is low, a write beats a start_i in the same cycle: that start is dropped and leaves no other effect.
- R10: done_o is 1 for exactly the cycle after an accepted start, meaning start_i=1 with no clear or write in that cycle. Otherwise done_o is 0.
- R11: Operands, op_word_i and sat_mode_i are sampled only on an accepted start. With no start, clear or write, the accumulator holds its value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one multiply-accumulate |
| op_word_i | input | 1 | 0 = long form, 1 = word form |
| sat_mode_i | input | 1 | Saturation mode |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| clear_i | input | 1 | Synchronous accumulator clear |
| wr_hi_en_i | input | 1 | Load high half from wr_data_i |
| wr_lo_en_i | input | 1 | Load low half from wr_data_i |
| wr_data_i | input | 32 | Write data |
| acc_hi_o | output | 32 | Accumulator high half |
| acc_lo_o | output | 32 | Accumulator low half |
| done_o | output | 1 | Pulses the cycle after an accepted start |

## Verification
The bench preloads the accumulator next to both word-form clamp thresholds and checks each side. A design that compared against the wrong bound, or forgot the marker value 1 in the high half, would return a wrapped sum or a wrong high half. Long-form saturation is checked with positive and negative sums whose high half has stray bits, so a swapped mask or a test on the wrong sign bit shows up. Same-cycle collisions of clear, write and start are also driven. They expose wrong priorities, which would leave a product mixed into loaded data or raise done for a dropped start. Random long and word operations with junk in the upper operand bits catch bad sign extension.

// File: rtl/mac_pkg.sv
package mac_pkg;
  parameter int unsigned MAC_DATA_W = 32;
  parameter int unsigned MAC_WORD_W = 16;

  typedef enum logic {
    MAC_LONG = 1'b0,
    MAC_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = MAC_DATA_W,
  parameter int unsigned WORD_W = MAC_WORD_W,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  mac_op_e                   op_i,
  input  logic [DATA_W-1:0]         a_i,
  input  logic [DATA_W-1:0]         b_i,
  output logic signed [PROD_W-1:0]  prod_o
);
  logic signed [DATA_W-1:0] a_ext, b_ext;

  always_comb begin
    if (op_i == MAC_WORD) begin
      a_ext = {{(DATA_W-WORD_W){a_i[WORD_W-1]}}, a_i[WORD_W-1:0]};
      b_ext = {{(DATA_W-WORD_W){b_i[WORD_W-1]}}, b_i[WORD_W-1:0]};
    end else begin
      a_ext = a_i;
      b_ext = b_i;
    end
    prod_o = PROD_W'(a_ext) * PROD_W'(b_ext);
  end
endmodule

// File: rtl/mac_sat.sv
module mac_sat
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = MAC_DATA_W,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned KEEP_W = DATA_W / 2 - 1
) (
  input  mac_op_e            op_i,
  input  logic               sat_i,
  input  logic [PROD_W-1:0]  acc_i,
  input  logic [PROD_W-1:0]  prod_i,
  output logic [PROD_W-1:0]  next_o
);
  localparam logic [DATA_W-1:0] UP_ONES   = {DATA_W{1'b1}} << (KEEP_W + 1);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~({DATA_W{1'b1}} << KEEP_W);
  localparam logic [DATA_W-1:0] LO_MAX    = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] LO_MIN    = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MARK      = DATA_W'(1);

  logic [PROD_W-1:0] sum;
  logic [DATA_W-1:0] sum_hi, sum_lo;
  logic              neg, fits;

  always_comb begin
    sum    = acc_i + prod_i;
    sum_hi = sum[PROD_W-1:DATA_W];
    sum_lo = sum[DATA_W-1:0];
    neg    = sum[PROD_W-1];
    // sign bits above bit DATA_W-1 all equal -> fits in signed DATA_W
    fits   = (&sum[PROD_W-1:DATA_W-1]) | ~(|sum[PROD_W-1:DATA_W-1]);
    next_o = sum;
    if (sat_i) begin
      if (op_i == MAC_LONG) begin
        next_o = {neg ? (sum_hi | UP_ONES) : (sum_hi & KEEP_MASK), sum_lo};
      end else if (!fits) begin
        next_o = {MARK, neg ? LO_MIN : LO_MAX};
      end
    end
  end
endmodule

// File: rtl/mac_acc_regs.sv
module mac_acc_regs
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = MAC_DATA_W,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               wr_hi_i,
  input  logic               wr_lo_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               acc_en_i,
  input  logic [PROD_W-1:0]  acc_next_i,
  output logic [DATA_W-1:0]  hi_o,
  output logic [DATA_W-1:0]  lo_o
);
  logic [DATA_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (clear_i) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_hi_i || wr_lo_i) begin
      if (wr_hi_i) hi_q <= wr_data_i;
      if (wr_lo_i) lo_q <= wr_data_i;
    end else if (acc_en_i) begin
      hi_q <= acc_next_i[PROD_W-1:DATA_W];
      lo_q <= acc_next_i[DATA_W-1:0];
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hi_q == '0 && lo_q == '0));
  // R9
  wr_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && wr_hi_i) |=> hi_q == $past(wr_data_i));
  // R9
  wr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && wr_lo_i) |=> lo_q == $past(wr_data_i));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !wr_hi_i && !wr_lo_i && !acc_en_i) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = MAC_DATA_W,
  parameter int unsigned WORD_W = MAC_WORD_W,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned KEEP_W = DATA_W / 2 - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_word_i,
  input  logic              sat_mode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              clear_i,
  input  logic              wr_hi_en_i,
  input  logic              wr_lo_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              done_o
);
  mac_op_e           op;
  logic              accept;
  logic [PROD_W-1:0] prod, acc_next;
  logic              done_q;

  assign op     = mac_op_e'(op_word_i);
  assign accept = start_i && !clear_i && !wr_hi_en_i && !wr_lo_en_i;

  mac_mult #(.DATA_W(DATA_W), .WORD_W(WORD_W)) mult_i (
    .op_i  (op),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .prod_o(prod)
  );

  mac_sat #(.DATA_W(DATA_W)) sat_i (
    .op_i  (op),
    .sat_i (sat_mode_i),
    .acc_i ({acc_hi_o, acc_lo_o}),
    .prod_i(prod),
    .next_o(acc_next)
  );

  mac_acc_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .wr_hi_i   (wr_hi_en_i),
    .wr_lo_i   (wr_lo_en_i),
    .wr_data_i (wr_data_i),
    .acc_en_i  (accept),
    .acc_next_i(acc_next),
    .hi_o      (acc_hi_o),
    .lo_o      (acc_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= accept;
  end
  assign done_o = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i && !wr_hi_en_i && !wr_lo_en_i) |=> done_o);
  // R10
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i || clear_i || wr_hi_en_i || wr_lo_en_i) |=> !done_o);
  // R4
  long_sat_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sat_mode_i && !op_word_i) |=>
      (&acc_hi_o[DATA_W-1:KEEP_W+1]) || (acc_hi_o[DATA_W-1:KEEP_W] == '0));
  // R5 R6 R7
  word_sat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sat_mode_i && op_word_i) |=>
      (acc_hi_o == DATA_W'(1) &&
       (acc_lo_o == {1'b0, {(DATA_W-1){1'b1}}} || acc_lo_o == {1'b1, {(DATA_W-1){1'b0}}}))
      || (acc_hi_o == {DATA_W{acc_lo_o[DATA_W-1]}}));
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0, op_word = 0, sat = 0, clr = 0, wr_hi = 0, wr_lo = 0;
  logic [31:0] opa = 0, opb = 0, wr_data = 0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int checks = 0, fails = 0;
  logic [63:0] exp_acc = 0;

  always #5 clk = ~clk;

  mac_sat_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_word_i(op_word),
    .sat_mode_i(sat), .opa_i(opa), .opb_i(opb), .clear_i(clr),
    .wr_hi_en_i(wr_hi), .wr_lo_en_i(wr_lo), .wr_data_i(wr_data),
    .acc_hi_o(acc_hi), .acc_lo_o(acc_lo), .done_o(done)
  );

  function automatic logic [63:0] model(logic [63:0] acc, logic w, logic s,
                                        logic [31:0] a, logic [31:0] b);
    longint pa, pb, sm;
    logic [31:0] h;
    pa = w ? longint'($signed(a[15:0])) : longint'($signed(a));
    pb = w ? longint'($signed(b[15:0])) : longint'($signed(b));
    sm = longint'(acc) + pa * pb;
    if (!s) return 64'(sm);
    if (!w) begin
      h = sm[63:32];
      if (sm < 0) h = h | 32'hFFFF_0000;
      else        h = h & 32'h0000_7FFF;
      return {h, sm[31:0]};
    end
    if (sm > 64'sh7FFF_FFFF)  return {32'd1, 32'h7FFF_FFFF};
    if (sm < -64'sh8000_0000) return {32'd1, 32'h8000_0000};
    return 64'(sm);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    start = 0; clr = 0; wr_hi = 0; wr_lo = 0;
  endtask

  task automatic load(logic [31:0] h, logic [31:0] l);
    @(negedge clk); wr_hi = 1; wr_data = h;
    @(negedge clk); wr_hi = 0; wr_lo = 1; wr_data = l;
    @(negedge clk); wr_lo = 0;
    exp_acc = {h, l};
    chk("R9 load", {acc_hi, acc_lo}, exp_acc);
  endtask

  task automatic mac(string req, logic w, logic s, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    start = 1; op_word = w; sat = s; opa = a; opb = b;
    exp_acc = model(exp_acc, w, s, a, b);
    @(negedge clk);
    start = 0; opa = $urandom(); opb = $urandom(); op_word = $urandom(); sat = $urandom();
    chk(req, {acc_hi, acc_lo}, exp_acc);
    chk("R10 done", 64'(done), 64'd1);
  endtask

  initial begin
    int unsigned cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #23;
    chk("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    @(negedge clk); rst_n = 1;

    // R2 long, no saturation
    mac("R2 long", 0, 0, 32'h0001_0000, 32'h0001_0000);
    mac("R2 long neg", 0, 0, 32'hFFFF_FFFF, 32'h0000_0005);
    mac("R2 long extremes", 0, 0, 32'h8000_0000, 32'h8000_0000);
    // R3 upper bits ignored in word form
    load(0, 0);
    mac("R3 word", 1, 0, 32'hABCD_FFFE, 32'h1234_0003);
    chk("R3 word value", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFF_FFFA);
    // R4 long saturation
    load(32'h1234_5678, 32'h0);
    mac("R4 long sat pos", 0, 1, 32'd1, 32'd1);
    chk("R4 pos mask", {acc_hi, acc_lo}, {32'h0000_5678, 32'd1});
    load(32'h8000_1234, 32'h0);
    mac("R4 long sat neg", 0, 1, 32'd1, 32'd1);
    chk("R4 neg force", {acc_hi, acc_lo}, {32'hFFFF_1234, 32'd1});
    // R5 / R6 / R7 word saturation boundaries
    load(32'h0, 32'h7FFF_FFFE);
    mac("R7 word at max", 1, 1, 32'd1, 32'd1);
    chk("R7 value", {acc_hi, acc_lo}, {32'h0, 32'h7FFF_FFFF});
    mac("R5 word above max", 1, 1, 32'd1, 32'd1);
    chk("R5 value", {acc_hi, acc_lo}, {32'd1, 32'h7FFF_FFFF});
    load(32'hFFFF_FFFF, 32'h8000_0001);
    mac("R7 word at min", 1, 1, 32'd1, 32'hFFFF);
    chk("R7 min value", {acc_hi, acc_lo}, {32'hFFFF_FFFF, 32'h8000_0000});
    mac("R6 word below min", 1, 1, 32'd1, 32'hFFFF);
    chk("R6 value", {acc_hi, acc_lo}, {32'd1, 32'h8000_0000});

    // R8 clear beats write and start
    @(negedge clk); clr = 1; wr_hi = 1; wr_lo = 1; wr_data = 32'hDEAD_BEEF; start = 1;
    @(negedge clk); idle_inputs();
    exp_acc = 0;
    chk("R8 clear", {acc_hi, acc_lo}, 64'd0);
    chk("R10 no done on clear", 64'(done), 64'd0);
    // R9 write beats start
    @(negedge clk); wr_lo = 1; wr_data = 32'h0000_0100; start = 1; op_word = 0; sat = 0;
    opa = 32'd1000; opb = 32'd1000;
    @(negedge clk); idle_inputs();
    exp_acc = {32'h0, 32'h100};
    chk("R9 write over start", {acc_hi, acc_lo}, exp_acc);
    chk("R10 no done on write", 64'(done), 64'd0);
    // R11 operand changes without start
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); opa = $urandom(); opb = $urandom(); op_word = $urandom(); sat = $urandom();
    end
    chk("R11 hold", {acc_hi, acc_lo}, exp_acc);
    chk("R10 done low idle", 64'(done), 64'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      a = $urandom(); b = $urandom();
      if ($urandom_range(0, 3) == 0) load($urandom(), $urandom());
      if ($urandom_range(0, 9) == 0) a = 32'h8000_0000 | a[15:0];
      mac($urandom_range(0, 1) ? "R2 R3 random" : "R4 R5 R6 R7 random",
          1'($urandom()), 1'($urandom()), a, b);
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 64'd0);
        chk("R11 random hold", {acc_hi, acc_lo}, exp_acc);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule